// File: doc/BRIEF.md
# Exception Entry Frame Sequencer

This block carries a processor from the point where an interrupt or exception is raised to the first instruction of its handler. The request carries a vector number, an error-code flag with its value, and the interrupted context: stack selector and pointer, code selector and instruction pointer, and the flags word. The block reads the 8-byte gate for the vector from a 256-entry gate table. If the handler runs at a more privileged ring, it fetches a fresh ring-0 stack from the task state area. It then writes the return frame downward, one 32-bit word per cycle, and presents the handler's register state.

All memory traffic goes through one 32-bit read port and one 32-bit write port. The read port holds each request until the memory answers. Writes are single-cycle and never stall. Task gates, descriptors that are not present, and unknown gate kinds are refused with a fault indication, and the context is left as it was.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, done_o, fault_o, rd_req_o and wr_en_o are low.
- R2: The gate is read as two words: the low word at idt_base_i + 8*vector, then the high word at that address + 4. Low word [15:0] holds handler offset bits 15:0 and [31:16] holds the handler selector. High word [31:16] holds offset bits 31:16, [15] is present, [14:13] is the gate privilege and [11:8] is the kind (0xE interrupt gate, 0xF trap gate).
- R3: The current ring is cs_i[1:0] and the handler ring is selector[1:0]. When the handler ring is numerically lower, the ring-0 stack pointer is read from tss_base_i + 4 and the ring-0 stack selector from bits [15:0] of tss_base_i + 8, before any write.
- R4: Frame words are written at addresses that step down by 4, starting 4 below the stack pointer in use, in this order: old SS (zero-extended), old ESP, EFLAGS, CS (zero-extended), EIP, error code. The first two are written only on a stack switch.
- R5: Without a ring change, no task state read occurs, the frame starts with EFLAGS on the old stack, and new_ss_o equals ss_i.
- R6: The error code is pushed only when err_flag_i is set and the vector is below 0x20. For vectors 0x20 and above, the flag has no effect.
- R7: new_eflags_o is the old flags with bit 17 (virtual-8086) and bit 8 (trap) cleared. Bit 9 (interrupt enable) is cleared for interrupt gates only. All other bits are kept.
- R8: new_cs_o is the gate selector, new_eip_o is the gate offset, and new_esp_o is the address of the last word written.
- R9: A gate whose present bit is clear, or whose kind is neither 0xE nor 0xF, causes no write. The block raises fault_o with done_o, and the new_* outputs equal the request's context.
- R10: done_o is a one-cycle pulse in the cycle after the last frame write, or after the faulting gate read.
- R11: A req_i that arrives while a sequence is in progress is ignored.
- R12: Each read request is held with a stable address until rd_valid_i, and one read is issued per response. Exactly one frame word is written per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an entry sequence (taken when idle) |
| vector_i | input | 8 | Interrupt or exception vector |
| err_flag_i | input | 1 | Error code accompanies the event |
| err_code_i | input | 32 | Error code value |
| idt_base_i | input | 32 | Base address of the gate table |
| tss_base_i | input | 32 | Base address of the task state area |
| ss_i | input | 16 | Current stack selector |
| esp_i | input | 32 | Current stack pointer |
| cs_i | input | 16 | Current code selector |
| eip_i | input | 32 | Return instruction pointer |
| eflags_i | input | 32 | Current flags word |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 32 | Read address |
| rd_data_i | input | 32 | Read data |
| rd_valid_i | input | 1 | Read data valid |
| wr_en_o | output | 1 | Write strobe |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 32 | Write data |
| done_o | output | 1 | New state valid (one cycle) |
| fault_o | output | 1 | Gate refused, qualifies done_o |
| new_cs_o | output | 16 | Handler code selector |
| new_eip_o | output | 32 | Handler instruction pointer |
| new_eflags_o | output | 32 | Handler flags |
| new_ss_o | output | 16 | Handler stack selector |
| new_esp_o | output | 32 | Handler stack pointer |

## Verification
The main function is tried with four ring and gate pairs: an outer-to-inner transition through an interrupt gate, a same-ring trap gate, a same-ring interrupt gate at ring 3, and an inner-ring stack on a high vector. Together they separate stack switching from flag clearing, since each pair varies one of the two. The error flag is applied at vectors 0x1F and 0x20 to locate the exception boundary exactly. Memory latency is varied from zero to three wait cycles to show that reads hold. A second request is injected mid-sequence to show that it leaves no trace in the reads or the frame. A descriptor that is not present and a task gate both exercise the fault path.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATE_LO,
    ST_GATE_HI,
    ST_TSS_SP,
    ST_TSS_SS,
    ST_PUSH,
    ST_DONE
  } seq_state_e;

  localparam logic [3:0] GATE_INTR = 4'hE;
  localparam logic [3:0] GATE_TRAP = 4'hF;

  // frame slot numbering; the first two are skipped without a stack switch
  localparam logic [2:0] SLOT_SS  = 3'd0;
  localparam logic [2:0] SLOT_SP  = 3'd1;
  localparam logic [2:0] SLOT_FL  = 3'd2;
  localparam logic [2:0] SLOT_CS  = 3'd3;
  localparam logic [2:0] SLOT_IP  = 3'd4;
  localparam logic [2:0] SLOT_ERR = 3'd5;

  localparam int FL_TRAP_BIT = 8;
  localparam int FL_IE_BIT   = 9;
  localparam int FL_V86_BIT  = 17;

  typedef struct packed {
    logic [15:0] sel;
    logic [31:0] off;
    logic        present;
    logic [1:0]  dpl;
    logic [3:0]  kind;
  } gate_t;

endpackage

// File: rtl/exc_gate_decode.sv
module exc_gate_decode
  import exc_entry_pkg::*;
(
  input  logic [31:0] lo_i,
  input  logic [31:0] hi_i,
  output gate_t       gate_o,
  output logic        usable_o,
  output logic        is_intr_o
);
  always_comb begin
    gate_o.sel     = lo_i[31:16];
    gate_o.off     = {hi_i[31:16], lo_i[15:0]};
    gate_o.present = hi_i[15];
    gate_o.dpl     = hi_i[14:13];
    gate_o.kind    = hi_i[11:8];
  end

  assign is_intr_o = (gate_o.kind == GATE_INTR);
  assign usable_o  = gate_o.present && (is_intr_o || gate_o.kind == GATE_TRAP);
endmodule

// File: rtl/exc_frame_word.sv
module exc_frame_word
  import exc_entry_pkg::*;
(
  input  logic [2:0]  slot_i,
  input  logic [15:0] ss_i,
  input  logic [31:0] esp_i,
  input  logic [31:0] eflags_i,
  input  logic [15:0] cs_i,
  input  logic [31:0] eip_i,
  input  logic [31:0] err_i,
  output logic [31:0] word_o
);
  always_comb begin
    unique case (slot_i)
      SLOT_SS: word_o = {16'h0, ss_i};
      SLOT_SP: word_o = esp_i;
      SLOT_FL: word_o = eflags_i;
      SLOT_CS: word_o = {16'h0, cs_i};
      SLOT_IP: word_o = eip_i;
      default: word_o = err_i;
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int AW             = 32,
  parameter int VW             = 8,
  parameter int EXC_VEC_LIMIT  = 32,
  parameter int TSS_SP0_OFS    = 4,
  parameter int TSS_SS0_OFS    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [VW-1:0] vector_i,
  input  logic          err_flag_i,
  input  logic [31:0]   err_code_i,
  input  logic [AW-1:0] idt_base_i,
  input  logic [AW-1:0] tss_base_i,
  input  logic [15:0]   ss_i,
  input  logic [31:0]   esp_i,
  input  logic [15:0]   cs_i,
  input  logic [31:0]   eip_i,
  input  logic [31:0]   eflags_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [31:0]   rd_data_i,
  input  logic          rd_valid_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [31:0]   wr_data_o,
  output logic          done_o,
  output logic          fault_o,
  output logic [15:0]   new_cs_o,
  output logic [31:0]   new_eip_o,
  output logic [31:0]   new_eflags_o,
  output logic [15:0]   new_ss_o,
  output logic [31:0]   new_esp_o
);
  localparam int          DESC_SHIFT = 3;
  localparam logic [AW-1:0] WORD_B   = AW'(4);

  seq_state_e st_q;
  logic [VW-1:0] vec_q;
  logic          errp_q, inner_q, fault_q, gintr_q;
  logic [31:0]   err_q, esp_q, eip_q, efl_q, lo_q, goff_q;
  logic [15:0]   ss_q, cs_q, nss_q, gsel_q;
  logic [AW-1:0] idt_q, tss_q, sp_q, gate_addr;
  logic [2:0]    slot_q, last_slot;

  gate_t g;
  logic  g_ok, g_intr, g_inner;
  logic [31:0] frame_w;

  exc_gate_decode i_dec (
    .lo_i(lo_q), .hi_i(rd_data_i),
    .gate_o(g), .usable_o(g_ok), .is_intr_o(g_intr)
  );

  exc_frame_word i_word (
    .slot_i(slot_q), .ss_i(ss_q), .esp_i(esp_q), .eflags_i(efl_q),
    .cs_i(cs_q), .eip_i(eip_q), .err_i(err_q), .word_o(frame_w)
  );

  assign g_inner   = g.sel[1:0] < cs_q[1:0];
  assign gate_addr = idt_q + (AW'(vec_q) << DESC_SHIFT);
  assign last_slot = errp_q ? SLOT_ERR : SLOT_IP;

  always_comb begin
    rd_req_o  = 1'b1;
    rd_addr_o = gate_addr;
    unique case (st_q)
      ST_GATE_LO: rd_addr_o = gate_addr;
      ST_GATE_HI: rd_addr_o = gate_addr + WORD_B;
      ST_TSS_SP:  rd_addr_o = tss_q + AW'(TSS_SP0_OFS);
      ST_TSS_SS:  rd_addr_o = tss_q + AW'(TSS_SS0_OFS);
      default:    rd_req_o  = 1'b0;
    endcase
  end

  assign wr_en_o   = (st_q == ST_PUSH);
  assign wr_addr_o = sp_q - WORD_B;
  assign wr_data_o = frame_w;
  assign done_o    = (st_q == ST_DONE);
  assign fault_o   = done_o && fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      {vec_q, errp_q, inner_q, fault_q, gintr_q} <= '0;
      {err_q, esp_q, eip_q, efl_q, lo_q, goff_q} <= '0;
      {ss_q, cs_q, nss_q, gsel_q} <= '0;
      {idt_q, tss_q, sp_q} <= '0;
      slot_q <= '0;
      new_cs_o <= '0; new_eip_o <= '0; new_eflags_o <= '0;
      new_ss_o <= '0; new_esp_o <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          vec_q   <= vector_i;
          errp_q  <= err_flag_i && (int'(vector_i) < EXC_VEC_LIMIT);
          err_q   <= err_code_i;
          idt_q   <= idt_base_i;
          tss_q   <= tss_base_i;
          ss_q    <= ss_i;
          esp_q   <= esp_i;
          cs_q    <= cs_i;
          eip_q   <= eip_i;
          efl_q   <= eflags_i;
          fault_q <= 1'b0;
          st_q    <= ST_GATE_LO;
        end
        ST_GATE_LO: if (rd_valid_i) begin
          lo_q <= rd_data_i;
          st_q <= ST_GATE_HI;
        end
        ST_GATE_HI: if (rd_valid_i) begin
          gsel_q  <= g.sel;
          goff_q  <= g.off;
          gintr_q <= g_intr;
          if (!g_ok) begin
            fault_q      <= 1'b1;
            new_cs_o     <= cs_q;
            new_eip_o    <= eip_q;
            new_eflags_o <= efl_q;
            new_ss_o     <= ss_q;
            new_esp_o    <= esp_q;
            st_q         <= ST_DONE;
          end else if (g_inner) begin
            inner_q <= 1'b1;
            st_q    <= ST_TSS_SP;
          end else begin
            inner_q <= 1'b0;
            sp_q    <= AW'(esp_q);
            nss_q   <= ss_q;
            slot_q  <= SLOT_FL;
            st_q    <= ST_PUSH;
          end
        end
        ST_TSS_SP: if (rd_valid_i) begin
          sp_q <= AW'(rd_data_i);
          st_q <= ST_TSS_SS;
        end
        ST_TSS_SS: if (rd_valid_i) begin
          nss_q  <= rd_data_i[15:0];
          slot_q <= SLOT_SS;
          st_q   <= ST_PUSH;
        end
        ST_PUSH: begin
          sp_q   <= sp_q - WORD_B;
          slot_q <= slot_q + 3'd1;
          if (slot_q == last_slot) begin
            new_cs_o  <= gsel_q;
            new_eip_o <= goff_q;
            new_eflags_o <= efl_q & ~((32'h1 << FL_V86_BIT) | (32'h1 << FL_TRAP_BIT) |
                                      (gintr_q ? (32'h1 << FL_IE_BIT) : 32'h0));
            new_ss_o  <= nss_q;
            new_esp_o <= 32'(sp_q - WORD_B);
            st_q      <= ST_DONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4: consecutive frame writes step down by one word
  a_r4_push_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) - WORD_B));

  // R12: read and write ports never active together
  a_r12_port_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_en_o));

  // R12: a pending read keeps its address until answered
  a_r12_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R7: successful entry leaves trap and virtual-8086 bits clear
  a_r7_flags_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> (!new_eflags_o[FL_V86_BIT] && !new_eflags_o[FL_TRAP_BIT]));

  // R8: handler stack pointer is the last word written
  a_r8_esp_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> (new_esp_o == 32'($past(wr_addr_o))));

  // R9: a refused gate is preceded by no write
  a_r9_fault_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !$past(wr_en_o));
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IDT = 32'h0000_8000;
  localparam logic [31:0] TSS = 32'h0000_4000;
  localparam logic [31:0] TSS_SP0 = 32'h0009_F000;
  localparam logic [15:0] TSS_SS0 = 16'h0010;
  localparam logic [31:0] HOFF = 32'hC012_3456;

  logic clk = 0, rst_n = 0;
  logic req = 0, err_flag = 0;
  logic [7:0] vector = 0;
  logic [31:0] err_code = 0, esp = 0, eip = 0, eflags = 0;
  logic [15:0] ss = 0, cs = 0;
  logic rd_req, rd_valid, wr_en, done, fault;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data, n_eip, n_efl, n_esp;
  logic [15:0] n_cs, n_ss;

  int checks = 0, errors = 0, cycles = 0, latency = 0, wcnt = 0;
  logic [31:0] desc_lo = 0, desc_hi = 0;
  logic [7:0]  mem_vec = 0;
  logic clr = 0;
  int rn = 0, wn = 0;
  logic [31:0] ra [8];
  logic [31:0] wa [8];
  logic [31:0] wd [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .vector_i(vector),
    .err_flag_i(err_flag), .err_code_i(err_code), .idt_base_i(IDT), .tss_base_i(TSS),
    .ss_i(ss), .esp_i(esp), .cs_i(cs), .eip_i(eip), .eflags_i(eflags),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data), .rd_valid_i(rd_valid),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .done_o(done), .fault_o(fault), .new_cs_o(n_cs), .new_eip_o(n_eip),
    .new_eflags_o(n_efl), .new_ss_o(n_ss), .new_esp_o(n_esp));

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (a == IDT + {21'h0, mem_vec, 3'b000}) return desc_lo;
    if (a == IDT + {21'h0, mem_vec, 3'b000} + 4) return desc_hi;
    if (a == TSS + 4) return TSS_SP0;
    if (a == TSS + 8) return {16'hBEEF, TSS_SS0};
    return 32'hDEAD_DEAD;
  endfunction

  always @(posedge clk) begin
    rd_valid <= 1'b0;
    if (clr) begin rn <= 0; wn <= 0; wcnt <= 0; end
    else begin
      if (rd_req && !rd_valid) begin
        if (wcnt >= latency) begin
          rd_valid <= 1'b1;
          rd_data  <= mem_rd(rd_addr);
          if (rn < 8) ra[rn] <= rd_addr;
          rn <= rn + 1;
          wcnt <= 0;
        end else wcnt <= wcnt + 1;
      end
      if (wr_en) begin
        if (wn < 8) begin wa[wn] <= wr_addr; wd[wn] <= wr_data; end
        wn <= wn + 1;
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run_case(input string name, input logic [7:0] vec, input logic ef,
                          input logic [15:0] cur_cs, input logic [15:0] hsel,
                          input logic [3:0] kind, input logic pres, input int lat,
                          input bit poke);
    logic inner, ok, perr;
    logic [31:0] sp0, exp_w [6];
    logic [15:0] exp_ss;
    int first, nw, nr, guard;
    logic [31:0] fl;
    @(negedge clk);
    clr = 1; latency = lat; mem_vec = vec;
    desc_lo = {hsel, HOFF[15:0]};
    desc_hi = {HOFF[31:16], pres, 2'b00, 1'b0, kind, 8'h00};
    vector = vec; err_flag = ef; err_code = 32'hE77C_0000 | 32'(vec);
    cs = cur_cs; ss = 16'h002B; esp = 32'h0012_FF80; eip = 32'h0040_1234;
    eflags = 32'h0003_0B47;
    @(negedge clk);
    clr = 0; req = 1;
    @(negedge clk);
    req = 0;
    if (poke) begin
      repeat (2) @(negedge clk);
      vector = 8'h99; err_flag = 1; req = 1;
      @(negedge clk);
      req = 0;
    end
    guard = 0;
    while (!done && guard < 200) begin @(negedge clk); guard++; end
    chk("R10", {name, " done seen"}, 32'(done), 32'd1);

    inner = hsel[1:0] < cur_cs[1:0];
    ok    = pres && (kind == 4'hE || kind == 4'hF);
    perr  = ef && (vec < 8'h20);
    sp0   = (ok && inner) ? TSS_SP0 : 32'h0012_FF80;
    exp_ss = inner ? TSS_SS0 : 16'h002B;
    exp_w[0] = 32'h0000_002B; exp_w[1] = 32'h0012_FF80; exp_w[2] = 32'h0003_0B47;
    exp_w[3] = {16'h0, cur_cs}; exp_w[4] = 32'h0040_1234; exp_w[5] = 32'hE77C_0000 | 32'(vec);
    first = inner ? 0 : 2;
    nw = ok ? (6 - first - (perr ? 0 : 1)) : 0;
    nr = (ok && inner) ? 4 : 2;

    chk("R12", {name, " read count"}, 32'(rn), 32'(nr));
    chk("R2", {name, " gate lo addr"}, ra[0], IDT + {21'h0, vec, 3'b000});
    chk("R2", {name, " gate hi addr"}, ra[1], IDT + {21'h0, vec, 3'b000} + 4);
    if (nr == 4) begin
      chk("R3", {name, " tss sp addr"}, ra[2], TSS + 4);
      chk("R3", {name, " tss ss addr"}, ra[3], TSS + 8);
    end
    chk(perr ? "R6" : "R4", {name, " write count"}, 32'(wn), 32'(nw));
    for (int k = 0; k < nw && k < 6; k++) begin
      chk("R4", {name, " frame addr"}, wa[k], sp0 - 32'(4 * (k + 1)));
      chk("R4", {name, " frame data"}, wd[k], exp_w[first + k]);
    end
    chk("R9", {name, " fault"}, 32'(fault), 32'(!ok));
    if (ok) begin
      fl = 32'h0003_0B47 & ~32'h0002_0100;
      if (kind == 4'hE) fl = fl & ~32'h0000_0200;
      chk("R7", {name, " new flags"}, n_efl, fl);
      chk("R8", {name, " new cs"}, 32'(n_cs), 32'(hsel));
      chk("R8", {name, " new eip"}, n_eip, HOFF);
      chk("R8", {name, " new esp"}, n_esp, sp0 - 32'(4 * nw));
      chk(inner ? "R3" : "R5", {name, " new ss"}, 32'(n_ss), 32'(exp_ss));
    end else begin
      chk("R9", {name, " cs kept"}, 32'(n_cs), 32'(cur_cs));
      chk("R9", {name, " eip kept"}, n_eip, 32'h0040_1234);
      chk("R9", {name, " flags kept"}, n_efl, 32'h0003_0B47);
      chk("R9", {name, " ss kept"}, 32'(n_ss), 32'h002B);
      chk("R9", {name, " esp kept"}, n_esp, 32'h0012_FF80);
    end
    @(negedge clk);
    chk("R10", {name, " done pulse ends"}, 32'(done), 32'd0);
    if (poke) chk("R11", {name, " busy request dropped"}, 32'(rn + wn), 32'(nr + nw));
  endtask

  task automatic reset_check();
    repeat (3) @(negedge clk);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "fault", 32'(fault), 0);
    chk("R1", "rd_req", 32'(rd_req), 0);
    chk("R1", "wr_en", 32'(wr_en), 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    reset_check();
    // ring3 -> ring0 interrupt gate, page-fault-like vector with code
    run_case("inner_intr",  8'h0E, 1'b1, 16'h001B, 16'h0008, 4'hE, 1'b1, 0, 1'b0);
    // same ring trap gate, no code, slow memory
    run_case("same_trap",   8'h03, 1'b0, 16'h0008, 16'h0008, 4'hF, 1'b1, 3, 1'b0);
    // error flag on last exception vector is honoured
    run_case("vec_1f_err",  8'h1F, 1'b1, 16'h0008, 16'h0008, 4'hE, 1'b1, 1, 1'b0);
    // error flag on first external vector is ignored (R6)
    run_case("vec_20_err",  8'h20, 1'b1, 16'h001B, 16'h0008, 4'hF, 1'b1, 0, 1'b0);
    // ring3 handler from ring3: no switch, interrupt gate (R5)
    run_case("ring3_intr",  8'h80, 1'b0, 16'h001B, 16'h001B, 4'hE, 1'b1, 2, 1'b0);
    // not present and task gate are refused (R9)
    run_case("not_present", 8'h0D, 1'b1, 16'h001B, 16'h0008, 4'hE, 1'b0, 0, 1'b0);
    run_case("task_gate",   8'h08, 1'b1, 16'h001B, 16'h0008, 4'h5, 1'b1, 1, 1'b0);
    // second request while busy (R11)
    run_case("busy_poke",   8'h0E, 1'b1, 16'h001B, 16'h0008, 4'hE, 1'b1, 2, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule